// File: doc/BRIEF.md
# Two-Key Register Write Gate

This block guards a peripheral register file against accidental writes. It watches a simple write port (strobe, address, data). It lets writes through to the protected registers only after software has opened it with two magic words. The first word goes to a key location at offset 0x70 and the second to a key location at offset 0x74, in that order. Until both have landed correctly, every write aimed at a protected register is discarded without any error indication.

Once open, the gate stays open until the next reset. The key locations are never protected themselves. Software can poll the gate state through bit 23 of the control word at offset 0x50 on a registered read port, and reads work whether the gate is open or closed. The qualified write strobe, address and data leave the block registered, one cycle after the incoming write, ready to drive the protected register file.

Top module: `keyed_write_gate`

## Requirements
- R1: During and after synchronous reset (active high) the gate is closed: `unlocked`=0, `prot_wr`=0, `rd_data`=0.
- R2: A write of 0x83E70B13 to offset 0x70 followed later by a write of 0x95A4F1E0 to offset 0x74 opens the gate; `unlocked` rises in the cycle after the second key write.
- R3: A write to offset 0x74 while the first key has not been accepted never opens the gate, whatever its data.
- R4: After the first key is accepted, a write of any wrong value to 0x74, or any write to 0x70, discards the progress; a correct second key written afterwards does not open the gate.
- R5: After the first key is accepted, writes to addresses other than the two key offsets do not disturb the progress.
- R6: While the gate is closed, writes to non-key addresses never raise `prot_wr`.
- R7: While the gate is open, a write to a non-key address raises `prot_wr` for one cycle, one cycle later, with `prot_addr` and `prot_data` equal to the write's address and data.
- R8: Writes to either key offset never raise `prot_wr`.
- R9: Once open, the gate stays open under any writes, including wrong key values, until reset.
- R10: `rd_data` is registered: one cycle after `rd_addr` is 0x50 it holds the gate state in bit 23 with all other bits 0; for any other address it is 0. Reads work whether the gate is open or closed.
- R11: Reset closes an open gate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W (8) | Write byte offset |
| wr_data | input | DATA_W (32) | Write data |
| rd_addr | input | ADDR_W (8) | Read byte offset |
| prot_wr | output | 1 | Qualified write strobe to protected registers |
| prot_addr | output | ADDR_W (8) | Address of the qualified write |
| prot_data | output | DATA_W (32) | Data of the qualified write |
| rd_data | output | DATA_W (32) | Registered read data (control word status) |
| unlocked | output | 1 | Gate open |

## Verification
The hardest situation to reach from the ports is the half-open state: the first key has been accepted and other traffic, or a spoiled second key, then arrives before the real second key. Directed sequences build exactly this: first key, unrelated writes, then the second key; first key, first key again, then the second key; first key, a wrong second key, then the correct one. Random traffic is biased towards the two magic values at the two key offsets, so that half-open states arise repeatedly between periodic resets. A bench model of the gate predicts the outcome of each of these sequences.

// File: rtl/kwg_pkg.sv
package kwg_pkg;
  typedef enum logic [1:0] {
    GATE_CLOSED = 2'd0,
    GATE_ARMED  = 2'd1,
    GATE_OPEN   = 2'd2
  } gate_state_e;
endpackage

// File: rtl/kwg_match.sv
// Decodes one key location: a write hit and a hit carrying the magic word.
module kwg_match #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] LOC = '0,
  parameter logic [DATA_W-1:0] MAGIC = '0
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hit,
  output logic              good
);
  always_comb begin
    hit  = wr_en && (wr_addr == LOC);
    good = hit && (wr_data == MAGIC);
  end
endmodule

// File: rtl/kwg_fsm.sv
// Gate sequencer: closed -> armed on first key, armed -> open on second key.
module kwg_fsm
  import kwg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        k0_hit,
  input  logic        k0_good,
  input  logic        k1_hit,
  input  logic        k1_good,
  output gate_state_e state,
  output logic        open
);
  gate_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      GATE_CLOSED: if (k0_good) nxt = GATE_ARMED;
      GATE_ARMED: begin
        if (k1_good)              nxt = GATE_OPEN;
        else if (k0_hit || k1_hit) nxt = GATE_CLOSED;
      end
      GATE_OPEN:   nxt = GATE_OPEN;
      default:     nxt = GATE_CLOSED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= GATE_CLOSED;
    else     state <= nxt;
  end

  assign open = (state == GATE_OPEN);
endmodule

// File: rtl/kwg_fwd.sv
// Registered write forwarding and status read-back.
module kwg_fwd #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTL_LOC = '0,
  parameter int STATUS_BIT = 23
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              key_hit,
  input  logic              open,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              prot_wr,
  output logic [ADDR_W-1:0] prot_addr,
  output logic [DATA_W-1:0] prot_data,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] status_word;

  always_comb begin
    for (int b = 0; b < DATA_W; b++)
      status_word[b] = (b == STATUS_BIT) ? open : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_wr   <= 1'b0;
      prot_addr <= '0;
      prot_data <= '0;
      rd_data   <= '0;
    end else begin
      prot_wr <= wr_en && open && !key_hit;
      if (wr_en && open && !key_hit) begin
        prot_addr <= wr_addr;
        prot_data <= wr_data;
      end
      rd_data <= (rd_addr == CTL_LOC) ? status_word : '0;
    end
  end
endmodule

// File: rtl/keyed_write_gate.sv
module keyed_write_gate #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] KEY_A_LOC = 8'h70,
  parameter logic [ADDR_W-1:0] KEY_B_LOC = 8'h74,
  parameter logic [ADDR_W-1:0] CTL_LOC   = 8'h50,
  parameter logic [DATA_W-1:0] KEY_A_VAL = 32'h83E7_0B13,
  parameter logic [DATA_W-1:0] KEY_B_VAL = 32'h95A4_F1E0,
  parameter int STATUS_BIT = 23
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              prot_wr,
  output logic [ADDR_W-1:0] prot_addr,
  output logic [DATA_W-1:0] prot_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              unlocked
);
  import kwg_pkg::*;

  localparam int NKEYS = 2;
  localparam logic [NKEYS-1:0][ADDR_W-1:0] LOCS   = {KEY_B_LOC, KEY_A_LOC};
  localparam logic [NKEYS-1:0][DATA_W-1:0] MAGICS = {KEY_B_VAL, KEY_A_VAL};

  logic [NKEYS-1:0] hit, good;
  gate_state_e state;
  logic open;

  for (genvar k = 0; k < NKEYS; k++) begin : g_key
    kwg_match #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOC(LOCS[k]), .MAGIC(MAGICS[k])
    ) u_match (
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .hit(hit[k]), .good(good[k])
    );
  end

  kwg_fsm u_fsm (
    .clk(clk), .rst(rst),
    .k0_hit(hit[0]), .k0_good(good[0]),
    .k1_hit(hit[1]), .k1_good(good[1]),
    .state(state), .open(open)
  );

  kwg_fwd #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_LOC(CTL_LOC), .STATUS_BIT(STATUS_BIT)
  ) u_fwd (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .key_hit(|hit), .open(open), .rd_addr(rd_addr),
    .prot_wr(prot_wr), .prot_addr(prot_addr), .prot_data(prot_data),
    .rd_data(rd_data)
  );

  assign unlocked = open;
endmodule

// File: rtl/kwg_chk.sv
module kwg_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] KEY_A_LOC = 8'h70,
  parameter logic [ADDR_W-1:0] KEY_B_LOC = 8'h74,
  parameter logic [ADDR_W-1:0] CTL_LOC   = 8'h50,
  parameter logic [DATA_W-1:0] KEY_B_VAL = 32'h95A4_F1E0,
  parameter int STATUS_BIT = 23
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              prot_wr,
  input logic [ADDR_W-1:0] prot_addr,
  input logic [DATA_W-1:0] prot_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              unlocked
);
  // R1
  reset_closed_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!unlocked && !prot_wr && rd_data == '0));

  // R2
  open_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(wr_en && wr_addr == KEY_B_LOC && wr_data == KEY_B_VAL));

  // R6
  closed_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !unlocked) |=> !prot_wr);

  // R7
  open_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && unlocked && wr_addr != KEY_A_LOC && wr_addr != KEY_B_LOC)
    |=> (prot_wr && prot_addr == $past(wr_addr) && prot_data == $past(wr_data)));

  // R8
  key_never_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr == KEY_A_LOC || wr_addr == KEY_B_LOC)) |=> !prot_wr);

  // R9
  sticky_open_chk: assert property (@(posedge clk) disable iff (rst)
    unlocked |=> unlocked);

  // R10
  status_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_addr) == CTL_LOC)
    |-> (rd_data[STATUS_BIT] == $past(unlocked) && $countones(rd_data) == 32'($past(unlocked))));
endmodule

bind keyed_write_gate kwg_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_A_LOC(KEY_A_LOC), .KEY_B_LOC(KEY_B_LOC),
  .CTL_LOC(CTL_LOC), .KEY_B_VAL(KEY_B_VAL), .STATUS_BIT(STATUS_BIT)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .prot_wr(prot_wr), .prot_addr(prot_addr), .prot_data(prot_data),
  .rd_data(rd_data), .unlocked(unlocked)
);

// File: tb/keyed_write_gate_bench.sv
module keyed_write_gate_bench;
  localparam logic [7:0]  KA = 8'h70, KB = 8'h74, CTL = 8'h50;
  localparam logic [31:0] VA = 32'h83E7_0B13, VB = 32'h95A4_F1E0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic        prot_wr;
  logic [7:0]  prot_addr;
  logic [31:0] prot_data, rd_data;
  logic        unlocked;

  int checks = 0, errors = 0;
  int mstate = 0; // 0 closed, 1 armed, 2 open

  always #2 clk = ~clk;

  keyed_write_gate u_keyed_write_gate (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .prot_wr(prot_wr), .prot_addr(prot_addr),
    .prot_data(prot_data), .rd_data(rd_data), .unlocked(unlocked)
  );

  function automatic int next_state(int s, logic [7:0] a, logic [31:0] d);
    if (s == 0) return (a == KA && d == VA) ? 1 : 0;
    if (s == 1) begin
      if (a == KB && d == VB) return 2;
      if (a == KA || a == KB) return 0;
      return 1;
    end
    return 2;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mstate = 0;
    @(negedge clk);
  endtask

  task automatic wr(string req, logic [7:0] a, logic [31:0] d);
    logic exp_fwd;
    exp_fwd = (mstate == 2) && a != KA && a != KB;
    mstate = next_state(mstate, a, d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    @(negedge clk);
    check(req, prot_wr, exp_fwd);
    if (exp_fwd) check(req, {prot_addr, prot_data}, {a, d});
    check(req, unlocked, mstate == 2);
  endtask

  task automatic rd(string req, logic [7:0] a);
    rd_addr = a;
    @(posedge clk); #1;
    @(negedge clk);
    check(req, rd_data, (a == CTL && mstate == 2) ? 64'(32'h0080_0000) : 64'd0);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    @(negedge clk);
    // R1: reset state
    check("R1", {prot_wr, unlocked}, 0);
    do_reset();
    check("R1", {prot_wr, unlocked, rd_data}, 0);
    rd("R10", CTL);
    // R3: second key first
    wr("R3", KB, VB);
    wr("R3", KB, VB);
    // R6: closed drops
    wr("R6", 8'h10, 32'hDEAD_BEEF);
    // R5 + R2: armed, unrelated traffic, then second key
    wr("R2", KA, VA);
    wr("R5", 8'h20, 32'h1);
    wr("R6", CTL, 32'hFFFF_FFFF);
    rd("R10", CTL);
    wr("R2", KB, VB);
    rd("R10", CTL);
    rd("R10", 8'h54);
    // R7 forwarding, R8 key never forwarded, R9 sticky
    wr("R7", 8'h08, 32'h1234_5678);
    wr("R8", KA, 32'h0);
    wr("R9", KB, 32'h0);
    wr("R7", CTL, 32'h0300_0000);
    // R11
    do_reset();
    check("R11", unlocked, 0);
    // R4: wrong second key, then correct one
    wr("R4", KA, VA);
    wr("R4", KB, VA);
    wr("R4", KB, VB);
    // R4: first key twice
    wr("R4", KA, VA);
    wr("R4", KA, VA);
    wr("R4", KB, VB);
    // random phase
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a; logic [31:0] d; int p;
      if (i % 50 == 0) do_reset();
      p = $urandom_range(0, 9);
      a = (p < 4) ? KA : (p < 7) ? KB : (p < 8) ? CTL : 8'($urandom);
      p = $urandom_range(0, 9);
      d = (p < 4) ? VA : (p < 8) ? VB : $urandom;
      wr("R7", a, d);
      if (i % 7 == 0) rd("R10", (i % 14 == 0) ? CTL : 8'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule